// File: doc/BRIEF.md
# Time Mark Trigger Scheduler

This block keeps a small table of time marks that make up one node's part of a time-triggered bus schedule. The table holds only the slots this node sends in or wants to watch. Each entry names a trigger kind and the message buffer it serves. Every clock, each armed entry is compared with the running cycle time. On a match the block emits a one-cycle pulse on the output for that kind, with the linked buffer index alongside it.

There are four trigger kinds: transmit, receive-check, reference-transmit and watch. A receive-check tests whether its buffer took in a fresh frame since the last committed reference, and records the result in a per-buffer missing-message bit. A watch trigger means the reference message did not come, so it sets a sticky error flag.

A host write port loads entries. A commit pulse marks each accepted reference and starts a new basic cycle. Storing the messages and sending the frames are left to the logic around this block.

Top module: `tmark_sched`

## Requirements
- R1: After synchronous reset, all four trigger pulses, `trig_buf`, `miss_msg` and `ref_missing` are zero.
- R2: When `cycle_time` equals the mark of a valid armed entry at a clock edge, the block pulses the output selected by its kind for one cycle, starting at that edge. Kind codes: 00 `tx_trig`, 01 `rx_trig`, 10 `ref_trig`, 11 `watch_trig`. `trig_buf` carries the entry's buffer index during the pulse.
- R3: An entry whose valid bit is 0 never produces a pulse.
- R4: Once an entry has fired, it does not fire again until `ref_commit` is pulsed or the entry is rewritten, even if `cycle_time` equals its mark again.
- R5: If several entries match at the same edge, they are reported one per cycle in rising entry index order. The lowest index goes first.
- R6: A host write (`wr_en`) to an entry replaces its mark, kind, buffer and valid bit, and re-arms it.
- R7: When a receive-check fires for buffer b, `miss_msg[b]` becomes 1 if no `rx_frame_valid` for b came after the last `ref_commit`, and becomes 0 otherwise.
- R8: A watch pulse sets `ref_missing`. The flag stays set until `err_clr` is pulsed, which clears it.
- R9: A `ref_commit` pulse also clears `ref_missing`.
- R10: At most one of the four trigger pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_time | input | 16 | Running cycle time |
| ref_commit | input | 1 | Pulse: a reference was accepted and a new basic cycle begins |
| wr_en | input | 1 | Host write strobe for one entry |
| wr_addr | input | 3 | Entry index to write |
| wr_mark | input | 16 | Time mark to store |
| wr_kind | input | 2 | Trigger kind code |
| wr_buf | input | 3 | Linked buffer index |
| wr_valid | input | 1 | Entry enable bit |
| err_clr | input | 1 | Host write that clears the missing-reference flag |
| rx_frame_valid | input | 1 | Pulse: a frame was stored in a buffer |
| rx_frame_buf | input | 3 | Buffer that took the frame |
| tx_trig | output | 1 | Transmit trigger pulse |
| rx_trig | output | 1 | Receive-check trigger pulse |
| ref_trig | output | 1 | Reference-transmit trigger pulse |
| watch_trig | output | 1 | Watch trigger pulse |
| trig_buf | output | 3 | Buffer index of the current pulse |
| miss_msg | output | 8 | Per-buffer missing-message status |
| ref_missing | output | 1 | Sticky missing-reference error |

## Verification
Assertions check the following on every cycle:
- only one kind of pulse appears at a time;
- an entry that was granted is not granted again next cycle;
- any pending match produces a grant;
- the error flag follows its set, hold and clear rules.

Other behaviour only the bench's scenarios can show. These are the exact cycle a pulse lands in relative to the match, the ordering of two entries that share one mark, and silence from invalid or already-fired entries across a full sweep. Also the receive-check verdict depending on which buffers took frames, and rewrites re-arming an entry.

// File: rtl/tms_pkg.sv
package tms_pkg;

    localparam int TMS_ENT    = 8;
    localparam int TMS_MARK_W = 16;
    localparam int TMS_BUF_W  = 3;
    localparam int TMS_IDX_W  = $clog2(TMS_ENT);
    localparam int TMS_NBUF   = 1 << TMS_BUF_W;

    typedef enum logic [1:0] {
        TK_TX    = 2'b00,
        TK_RX    = 2'b01,
        TK_REF   = 2'b10,
        TK_WATCH = 2'b11
    } trig_kind_e;

    typedef struct packed {
        logic                  valid;
        trig_kind_e            kind;
        logic [TMS_BUF_W-1:0]  bufi;
        logic [TMS_MARK_W-1:0] mark;
    } tms_entry_t;

    // index of the lowest set bit (0 when none set)
    function automatic logic [TMS_IDX_W-1:0] lowest_idx(input logic [TMS_ENT-1:0] v);
        logic [TMS_IDX_W-1:0] r;
        r = '0;
        for (int i = TMS_ENT - 1; i >= 0; i--) begin
            if (v[i]) r = TMS_IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/tms_mem.sv
module tms_mem
    import tms_pkg::*;
#(
    parameter int N_ENT  = TMS_ENT,
    parameter int IDX_W  = $clog2(N_ENT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_addr,
    input  tms_entry_t            wr_ent,
    input  logic                  ref_commit,
    input  logic [TMS_MARK_W-1:0] cycle_time,
    input  logic [N_ENT-1:0]      grant,
    output logic [N_ENT-1:0]      req,
    output tms_entry_t            ent [N_ENT]
);

    logic [N_ENT-1:0] fired_q;
    logic [N_ENT-1:0] pend_q;
    logic [N_ENT-1:0] hit;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic sel;
        assign sel    = wr_en && (wr_addr == IDX_W'(g));
        assign hit[g] = ent[g].valid && !fired_q[g] && (ent[g].mark == cycle_time);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g]     <= '0;
                fired_q[g] <= 1'b0;
                pend_q[g]  <= 1'b0;
            end else if (sel) begin
                ent[g]     <= wr_ent;
                fired_q[g] <= 1'b0;
                pend_q[g]  <= 1'b0;
            end else begin
                fired_q[g] <= ref_commit ? 1'b0 : (fired_q[g] | hit[g]);
                pend_q[g]  <= req[g] & ~grant[g];
            end
        end

        // R4: a granted entry is not granted again on the next cycle
        p_no_regrant_r4: assert property (@(posedge clk) disable iff (rst)
            (grant[g] && !ref_commit && !wr_en) |=> !grant[g]);
    end

    assign req = pend_q | hit;

endmodule

// File: rtl/tms_arb.sv
module tms_arb
    import tms_pkg::*;
#(
    parameter int N_ENT = TMS_ENT,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_ENT-1:0]     req,
    input  tms_entry_t           ent [N_ENT],
    output logic [N_ENT-1:0]     grant,
    output logic                 g_vld,
    output trig_kind_e           g_kind,
    output logic [TMS_BUF_W-1:0] g_buf
);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx   = lowest_idx(req);
        g_vld = |req;
        grant = '0;
        if (g_vld) grant[idx] = 1'b1;
        g_kind = ent[idx].kind;
        g_buf  = ent[idx].bufi;
    end

    // R5: any pending request yields exactly one grant inside the request set
    p_grant_in_req_r5: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> ($onehot0(grant) && (|(grant & req))));

endmodule

// File: rtl/tms_status.sv
module tms_status
    import tms_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 g_vld,
    input  trig_kind_e           g_kind,
    input  logic [TMS_BUF_W-1:0] g_buf,
    input  logic                 rx_frame_valid,
    input  logic [TMS_BUF_W-1:0] rx_frame_buf,
    input  logic                 ref_commit,
    input  logic                 err_clr,
    output logic                 tx_trig,
    output logic                 rx_trig,
    output logic                 ref_trig,
    output logic                 watch_trig,
    output logic [TMS_BUF_W-1:0] trig_buf,
    output logic [TMS_NBUF-1:0]  miss_msg,
    output logic                 ref_missing
);

    logic [TMS_NBUF-1:0] seen_q, seen_n;
    logic                watch_go;

    assign watch_go = g_vld && (g_kind == TK_WATCH);

    always_comb begin
        seen_n = ref_commit ? '0 : seen_q;
        if (rx_frame_valid) seen_n[rx_frame_buf] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_trig     <= 1'b0;
            rx_trig     <= 1'b0;
            ref_trig    <= 1'b0;
            watch_trig  <= 1'b0;
            trig_buf    <= '0;
            miss_msg    <= '0;
            ref_missing <= 1'b0;
            seen_q      <= '0;
        end else begin
            tx_trig    <= g_vld && (g_kind == TK_TX);
            rx_trig    <= g_vld && (g_kind == TK_RX);
            ref_trig   <= g_vld && (g_kind == TK_REF);
            watch_trig <= watch_go;
            trig_buf   <= g_vld ? g_buf : '0;
            seen_q     <= seen_n;
            if (g_vld && (g_kind == TK_RX)) miss_msg[g_buf] <= !seen_q[g_buf];
            if (watch_go)                    ref_missing <= 1'b1;
            else if (err_clr || ref_commit)  ref_missing <= 1'b0;
        end
    end

    // R10: pulses are mutually exclusive
    p_one_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_trig, rx_trig, ref_trig, watch_trig}));
    // R8: a watch pulse comes with the error flag raised
    p_watch_sets_r8: assert property (@(posedge clk) disable iff (rst)
        watch_trig |-> ref_missing);
    // R8: the flag holds without a clear source
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ref_missing && !err_clr && !ref_commit) |=> ref_missing);
    // R9: commit clears the flag unless a watch fires at the same time
    p_commit_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (ref_commit && !watch_go) |=> !ref_missing);

endmodule

// File: rtl/tmark_sched.sv
module tmark_sched
    import tms_pkg::*;
#(
    parameter int N_ENT  = TMS_ENT,
    parameter int IDX_W  = $clog2(N_ENT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [TMS_MARK_W-1:0] cycle_time,
    input  logic                  ref_commit,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_addr,
    input  logic [TMS_MARK_W-1:0] wr_mark,
    input  logic [1:0]            wr_kind,
    input  logic [TMS_BUF_W-1:0]  wr_buf,
    input  logic                  wr_valid,
    input  logic                  err_clr,
    input  logic                  rx_frame_valid,
    input  logic [TMS_BUF_W-1:0]  rx_frame_buf,
    output logic                  tx_trig,
    output logic                  rx_trig,
    output logic                  ref_trig,
    output logic                  watch_trig,
    output logic [TMS_BUF_W-1:0]  trig_buf,
    output logic [TMS_NBUF-1:0]   miss_msg,
    output logic                  ref_missing
);

    tms_entry_t           wr_ent;
    tms_entry_t           ent [N_ENT];
    logic [N_ENT-1:0]     req, grant;
    logic                 g_vld;
    trig_kind_e           g_kind;
    logic [TMS_BUF_W-1:0] g_buf;

    always_comb begin
        wr_ent.valid = wr_valid;
        wr_ent.kind  = trig_kind_e'(wr_kind);
        wr_ent.bufi  = wr_buf;
        wr_ent.mark  = wr_mark;
    end

    tms_mem #(.N_ENT(N_ENT), .IDX_W(IDX_W)) i_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_ent(wr_ent),
        .ref_commit(ref_commit), .cycle_time(cycle_time), .grant(grant),
        .req(req), .ent(ent)
    );

    tms_arb #(.N_ENT(N_ENT), .IDX_W(IDX_W)) i_arb (
        .clk(clk), .rst(rst), .req(req), .ent(ent), .grant(grant),
        .g_vld(g_vld), .g_kind(g_kind), .g_buf(g_buf)
    );

    tms_status i_status (
        .clk(clk), .rst(rst), .g_vld(g_vld), .g_kind(g_kind), .g_buf(g_buf),
        .rx_frame_valid(rx_frame_valid), .rx_frame_buf(rx_frame_buf),
        .ref_commit(ref_commit), .err_clr(err_clr),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .ref_trig(ref_trig),
        .watch_trig(watch_trig), .trig_buf(trig_buf),
        .miss_msg(miss_msg), .ref_missing(ref_missing)
    );

endmodule

// File: tb/test_tmark_sched.sv
module test_tmark_sched;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cycle_time = 16'hFFFF;
    logic        ref_commit = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_mark = '0;
    logic [1:0]  wr_kind = '0;
    logic [2:0]  wr_buf = '0;
    logic        wr_valid = 1'b0;
    logic        err_clr = 1'b0;
    logic        rx_frame_valid = 1'b0;
    logic [2:0]  rx_frame_buf = '0;
    logic        tx_trig, rx_trig, ref_trig, watch_trig;
    logic [2:0]  trig_buf;
    logic [7:0]  miss_msg;
    logic        ref_missing;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    bi;
        int    ct;
        string tag;
    } exp_t;
    exp_t q[$];
    exp_t e;
    int   kd;

    always #5 clk = ~clk;

    tmark_sched i_tmark_sched (
        .clk(clk), .rst(rst), .cycle_time(cycle_time), .ref_commit(ref_commit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_mark(wr_mark), .wr_kind(wr_kind),
        .wr_buf(wr_buf), .wr_valid(wr_valid), .err_clr(err_clr),
        .rx_frame_valid(rx_frame_valid), .rx_frame_buf(rx_frame_buf),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .ref_trig(ref_trig),
        .watch_trig(watch_trig), .trig_buf(trig_buf),
        .miss_msg(miss_msg), .ref_missing(ref_missing)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input int bi, input int ct, input string tag);
        exp_t x;
        x.kind = kind; x.bi = bi; x.ct = ct; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input int m, input int k, input int b, input bit v);
        wr_en = 1'b1; wr_addr = 3'(a); wr_mark = 16'(m);
        wr_kind = 2'(k); wr_buf = 3'(b); wr_valid = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic commit();
        ref_commit = 1'b1; tick(); ref_commit = 1'b0;
    endtask

    task automatic frame(input int b);
        rx_frame_valid = 1'b1; rx_frame_buf = 3'(b); tick(); rx_frame_valid = 1'b0;
    endtask

    task automatic sweep(input int lo, input int hi, input string tag);
        for (int t = lo; t <= hi; t++) begin
            cycle_time = 16'(t);
            tick();
        end
        cycle_time = 16'hFFFF;
        tick(); tick();
        chk({tag, " queue drained"}, q.size(), 0);
    endtask

    // monitor: pops the scoreboard on every pulse
    always @(negedge clk) begin
        if (!rst && (tx_trig || rx_trig || ref_trig || watch_trig)) begin
            chk("R10 single pulse", $countones({tx_trig, rx_trig, ref_trig, watch_trig}), 1);
            kd = tx_trig ? 0 : rx_trig ? 1 : ref_trig ? 2 : 3;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R3/R4 unexpected pulse actual kind=%0d buf=%0d ct=%0d expected none",
                         kd, trig_buf, cycle_time);
            end else begin
                e = q.pop_front();
                if (kd != e.kind || int'(trig_buf) != e.bi || int'(cycle_time) != e.ct) begin
                    errors++;
                    $display("FAIL %s actual kind=%0d buf=%0d ct=%0d expected kind=%0d buf=%0d ct=%0d",
                             e.tag, kd, trig_buf, cycle_time, e.kind, e.bi, e.ct);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 pulses", {tx_trig, rx_trig, ref_trig, watch_trig}, 0);
        chk("R1 trig_buf", trig_buf, 0);
        chk("R1 miss_msg", miss_msg, 0);
        chk("R1 ref_missing", ref_missing, 0);

        // schedule: kind 0 TX, 1 RX, 2 REF, 3 WATCH
        wr(0, 100, 0, 1, 1);
        wr(1, 200, 1, 2, 1);
        wr(2, 300, 2, 0, 1);
        wr(3, 400, 3, 0, 1);
        wr(4, 500, 0, 5, 0);   // R3 invalid entry
        wr(5, 600, 0, 3, 1);
        wr(6, 600, 1, 4, 1);   // R5 shares a mark with entry 5
        wr(7, 700, 0, 6, 0);
        commit();
        frame(4);

        push(0, 1, 101, "R2 tx");
        push(1, 2, 201, "R2 rx");
        push(2, 0, 301, "R2 ref");
        push(3, 0, 401, "R2 watch");
        push(0, 3, 601, "R5 lower first");
        push(1, 4, 602, "R5 higher next");
        sweep(0, 800, "R2/R3/R5");
        chk("R7 miss_msg verdicts", miss_msg, 8'h04);
        chk("R8 flag set", ref_missing, 1);

        // R4 no refire without commit
        sweep(0, 800, "R4");
        chk("R8 flag sticky", ref_missing, 1);
        err_clr = 1'b1; tick(); err_clr = 1'b0;
        chk("R8 cleared by host", ref_missing, 0);

        // R6 rewrite enables and re-arms
        wr(4, 50, 0, 5, 1);
        wr(0, 100, 0, 7, 1);
        push(0, 5, 51, "R6 enabled entry");
        push(0, 7, 101, "R6 re-armed entry");
        sweep(0, 150, "R6");

        // R7 frame seen after commit clears the bit
        commit();
        frame(2);
        push(1, 2, 201, "R7 rx");
        sweep(195, 205, "R7");
        chk("R7 miss cleared", miss_msg, 8'h00);

        // R9 commit clears the error
        push(3, 0, 401, "R9 watch");
        sweep(395, 405, "R9");
        chk("R9 flag before commit", ref_missing, 1);
        commit();
        chk("R9 cleared by commit", ref_missing, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule